// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Port

This block is a parameterised universal storage and shift register, eight bits wide by default. On every rising clock edge it holds its contents, moves them one place toward the top bit, moves them one place toward bit 0, or loads every bit at once from a parallel port. Two select pins choose between these four actions. A clear input, active low, empties the register at once, without waiting for the clock.

The parallel port is shared between input and output. In silicon it is a single set of tristate pins. Here it is split into three signals: an input vector, an output vector that always shows the register, and one drive-enable flag. The flag tells a pad or bus wrapper whether the block should drive the pins. The block drives the port only when both active-low output enables are low and no load is selected. Selecting a load always releases the port so that it can act as an input, whatever the enables say.

A serial input and a serial output sit at each end of the register, and the serial outputs are always driven. Units are chained outside the block: top-bit output to the next unit's low-end input, and bit-0 output to the previous unit's high-end input. Closing that chain into a ring recirculates every bit of every unit. All pins are plain levels sampled on the clock edge. The block takes a new command on every cycle, so it has no valid/ready handshake and never applies back-pressure.

Top module: `usr8_shared_io`

## Requirements
- R1: While `rst_n` is low, the register is zero (`bus_out` = 0). This takes effect as soon as `rst_n` falls, including in the middle of a clock cycle, and every other input is ignored.
- R2: `mode_sel` = 2'b00 (hold): the register keeps its value across the clock edge.
- R3: `mode_sel` = 2'b01 (shift up): on the edge, each bit moves to the next higher index, and bit 0 takes `ser_in_lo`.
- R4: `mode_sel` = 2'b10 (shift down): on the edge, each bit moves to the next lower index, and the top bit takes `ser_in_hi`.
- R5: `mode_sel` = 2'b11 (load): on the edge, the register takes `bus_in`, whatever `oe_a_n` and `oe_b_n` are.
- R6: While `mode_sel` = 2'b11, `bus_drive` is 0, even when both enables are low.
- R7: While `oe_a_n` or `oe_b_n` is high, `bus_drive` is 0.
- R8: `bus_drive` is 1 when both enables are low and `mode_sel` is not 2'b11. `bus_out` always shows the register contents.
- R9: `ser_out_lo` equals register bit 0 and `ser_out_hi` equals the top bit at all times, whatever the enables are.
- R10: Two units in a ring (each unit's `ser_out_hi` feeding the other unit's `ser_in_lo`) that are shifted up 16 times return to their starting 16 bits. After each edge, the pair {second, first} equals the previous pair rotated left by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Action select: 00 hold, 01 up, 10 down, 11 load |
| oe_a_n | input | 1 | Output enable A, active low |
| oe_b_n | input | 1 | Output enable B, active low |
| ser_in_lo | input | 1 | Serial input entering at bit 0 on an up-shift |
| ser_in_hi | input | 1 | Serial input entering at the top bit on a down-shift |
| bus_in | input | W | Parallel port, input side |
| bus_out | output | W | Parallel port, output side (the register value) |
| bus_drive | output | 1 | High when the port pins should be driven |
| ser_out_lo | output | 1 | Register bit 0 |
| ser_out_hi | output | 1 | Register top bit |

## Verification
The register results (`bus_out`, `ser_out_lo`, `ser_out_hi`) are due one clock edge after a command is applied. `bus_drive` follows the selects and enables with no clock in between, and a falling clear shows on `bus_out` within the same cycle. The driver applies each command 5 ns after a rising edge and checks `bus_drive` 1 ns later. It then queues the register value expected after the coming edge. The monitor takes that value off the queue and compares it 2 ns after that edge. The mid-cycle clear and the two-unit ring are checked directly, 1–2 ns after the event that causes them, while the queue is empty.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_mode_ctrl.sv
module usr_mode_ctrl
  import usr_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  output usr_mode_e  mode,
  output logic       bus_drive
);
  logic enables_low;

  assign mode        = usr_mode_e'(mode_sel);
  assign enables_low = ~oe_a_n & ~oe_b_n;
  // A load releases the port no matter what the enables say.
  assign bus_drive   = enables_low & (mode != MODE_LOAD);
endmodule

// File: rtl/usr_bit_cell.sv
module usr_bit_cell
  import usr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  usr_mode_e mode,
  input  logic      from_below,
  input  logic      from_above,
  input  logic      par_in,
  output logic      q
);
  logic d;

  always_comb begin
    case (mode)
      MODE_UP:   d = from_below;
      MODE_DOWN: d = from_above;
      MODE_LOAD: d = par_in;
      default:   d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/usr8_shared_io.sv
module usr8_shared_io
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic         ser_in_lo,
  input  logic         ser_in_hi,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_drive,
  output logic         ser_out_lo,
  output logic         ser_out_hi
);
  localparam int TOP = W - 1;

  usr_mode_e    mode;
  logic [W-1:0] q_vec;
  logic [W-1:0] below_v;
  logic [W-1:0] above_v;

  usr_mode_ctrl u_ctrl (
    .mode_sel  (mode_sel),
    .oe_a_n    (oe_a_n),
    .oe_b_n    (oe_b_n),
    .mode      (mode),
    .bus_drive (bus_drive)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign below_v[i] = ser_in_lo;
    end else begin : g_lo_n
      assign below_v[i] = q_vec[i-1];
    end
    if (i == TOP) begin : g_hi
      assign above_v[i] = ser_in_hi;
    end else begin : g_hi_n
      assign above_v[i] = q_vec[i+1];
    end

    usr_bit_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .from_below (below_v[i]),
      .from_above (above_v[i]),
      .par_in     (bus_in[i]),
      .q          (q_vec[i])
    );
  end

  assign bus_out    = q_vec;
  assign ser_out_lo = q_vec[0];
  assign ser_out_hi = q_vec[TOP];

  // Clear overrides everything while low.
  p_clear_r1: assert property (@(posedge clk) !rst_n |-> (bus_out == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |=> (q_vec == $past(q_vec)));

  p_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) |=> (q_vec == {$past(q_vec[TOP-1:0]), $past(ser_in_lo)}));

  p_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10) |=> (q_vec == {$past(ser_in_hi), $past(q_vec[TOP:1])}));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |=> (bus_out == $past(bus_in)));

  p_release_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |-> !bus_drive);

  p_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a_n || oe_b_n) |-> !bus_drive);

  p_drive_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_a_n && !oe_b_n && mode_sel != 2'b11) |-> bus_drive);

  p_ser_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out_lo == bus_out[0]) && (ser_out_hi == bus_out[TOP]));
endmodule

// File: tb/usr8_shared_io_bench.sv
module usr8_shared_io_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [1:0]   sel;
  logic         oea, oeb, sli, shi;
  logic [W-1:0] pin;
  wire  [W-1:0] pout;
  wire          drv, slo, sho;

  usr8_shared_io #(.W(W)) u_usr8_shared_io (
    .clk(clk), .rst_n(rst_n), .mode_sel(sel), .oe_a_n(oea), .oe_b_n(oeb),
    .ser_in_lo(sli), .ser_in_hi(shi), .bus_in(pin), .bus_out(pout),
    .bus_drive(drv), .ser_out_lo(slo), .ser_out_hi(sho)
  );

  // Two-unit ring for R10
  logic [1:0]   c_sel;
  logic [W-1:0] ca_in, cb_in;
  wire  [W-1:0] ca_out, cb_out;
  wire          ca_lo, ca_hi, cb_lo, cb_hi, ca_drv, cb_drv;

  usr8_shared_io #(.W(W)) u_usr8_shared_io_a (
    .clk(clk), .rst_n(rst_n), .mode_sel(c_sel), .oe_a_n(1'b0), .oe_b_n(1'b0),
    .ser_in_lo(cb_hi), .ser_in_hi(cb_lo), .bus_in(ca_in), .bus_out(ca_out),
    .bus_drive(ca_drv), .ser_out_lo(ca_lo), .ser_out_hi(ca_hi)
  );
  usr8_shared_io #(.W(W)) u_usr8_shared_io_b (
    .clk(clk), .rst_n(rst_n), .mode_sel(c_sel), .oe_a_n(1'b0), .oe_b_n(1'b0),
    .ser_in_lo(ca_hi), .ser_in_hi(ca_lo), .bus_in(cb_in), .bus_out(cb_out),
    .bus_drive(cb_drv), .ser_out_lo(cb_lo), .ser_out_hi(cb_hi)
  );

  typedef struct {
    logic [W-1:0] val;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           checks = 0;
  int           fails  = 0;
  logic [W-1:0] model;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Driver: apply one command, check drive, queue the expected register.
  task automatic step(input logic [1:0] s, input logic l, input logic h,
                      input logic [W-1:0] p, input logic a, input logic b,
                      input string tag);
    logic  expd;
    string dtag;
    @(posedge clk);
    #5;
    sel = s; sli = l; shi = h; pin = p; oea = a; oeb = b;
    #1;
    expd = !a && !b && (s != 2'b11);
    dtag = (s == 2'b11) ? "R6" : ((a || b) ? "R7" : "R8");
    chk(drv == expd, dtag, {15'd0, drv}, {15'd0, expd});
    case (s)
      2'b00: model = model;
      2'b01: model = {model[W-2:0], l};
      2'b10: model = {h, model[W-1:1]};
      default: model = p;
    endcase
    sb.push_back('{model, tag});
  endtask

  // Monitor: compare queued expectations 2 ns after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(pout == e.val, e.tag, {8'd0, pout}, {8'd0, e.val});
        chk({sho, slo} == {e.val[W-1], e.val[0]}, "R9",
            {14'd0, sho, slo}, {14'd0, e.val[W-1], e.val[0]});
      end
    end
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] ring;
    rst_n = 1'b1; sel = 2'b00; oea = 1'b0; oeb = 1'b0; sli = 1'b0; shi = 1'b0;
    pin = '0; c_sel = 2'b00; ca_in = 8'hA5; cb_in = 8'h3C;
    #3 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(pout == 8'h00, "R1", {8'd0, pout}, 16'h0000);
    chk({sho, slo} == 2'b00, "R1", {14'd0, sho, slo}, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    model = '0;

    step(2'b11, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, "R5");
    step(2'b11, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b1, "R5");
    step(2'b00, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, "R2");
    step(2'b00, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, "R2");
    step(2'b01, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R3");
    step(2'b01, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, "R3");
    step(2'b01, 1'b1, 1'b0, 8'h55, 1'b0, 1'b1, "R3");
    step(2'b10, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R4");
    step(2'b10, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, "R4");
    step(2'b10, 1'b0, 1'b1, 8'h12, 1'b0, 1'b0, "R4");
    step(2'b11, 1'b0, 1'b0, 8'h81, 1'b0, 1'b1, "R5");
    step(2'b01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R9");
    step(2'b10, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, "R9");
    step(2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R8");
    step(2'b11, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, "R5");
    @(posedge clk);
    #3;

    // Mid-cycle clear, R1
    @(posedge clk);
    #7 rst_n = 1'b0;
    #1 chk(pout == 8'h00, "R1", {8'd0, pout}, 16'h0000);
    sel = 2'b11; pin = 8'hFF;
    @(posedge clk);
    #2 chk(pout == 8'h00, "R1", {8'd0, pout}, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    sel = 2'b00;
    model = '0;
    @(posedge clk);
    #2 chk(pout == 8'h00, "R2", {8'd0, pout}, 16'h0000);

    // Two-unit ring, R10
    @(negedge clk) c_sel = 2'b11;
    @(negedge clk) c_sel = 2'b01;
    ring = {cb_in, ca_in};
    chk({cb_out, ca_out} == ring, "R10", {cb_out, ca_out}, ring);
    for (int k = 0; k < 2 * W; k++) begin
      @(posedge clk);
      #2;
      ring = {ring[14:0], ring[15]};
      chk({cb_out, ca_out} == ring, "R10", {cb_out, ca_out}, ring);
    end
    chk(ring == {cb_in, ca_in}, "R10", ring, {cb_in, ca_in});
    @(negedge clk) c_sel = 2'b00;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule